// File: doc/BRIEF.md
# Skip-Mask Instruction Sequencer

This block sits between instruction fetch and execute in a small processor core. When a skip instruction is taken, the pipeline loads a 32-bit suppression mask. Each mask bit, starting with the least significant, governs one of the instructions that follow the skip in program order. A set bit suppresses that instruction. For the instruction currently being delivered, the sequencer reports whether it executes and how many words the program counter should move.

Two fetch modes are supported. In streamed mode every governed instruction is still fetched. A suppressed one is cancelled, and the counter always moves by one word. In local mode the counter jumps over a run of suppressed words and lands on the next active instruction, so active instructions issue back to back. A single jump is capped at eight words, and a longer run takes several all-suppressed steps. A fixed setup delay follows every mask load. A return-with-cancel strobe discards whatever pattern is pending.

Top module: `skip_seq`

## Requirements
- R1: After reset no pattern is pending: `ready_o`=1, `exec_o`=1 and `pc_inc_o`=1.
- R2: With `local_mode_i`=0, each step reports `pc_inc_o`=1 and `exec_o` equal to the inverse of the mask bit that governs the current instruction. Bit 0 of the loaded mask governs the first instruction after the skip.
- R3: With `local_mode_i`=1 and a run of k<8 consecutive set bits at the low end of the pending mask, a step reports `exec_o`=1 and `pc_inc_o`=k+1.
- R4: With `local_mode_i`=1 and a run of 8 or more set bits, a step reports `exec_o`=0 and `pc_inc_o`=8. The remainder of the run is handled by later steps.
- R5: Each step shifts the pending mask right by the reported `pc_inc_o`. Once the pending mask is zero, every step reports `exec_o`=1 and `pc_inc_o`=1.
- R6: After the cycle in which `load_i` is high, `ready_o` stays low for exactly 4 cycles. Valid and advance during those cycles do not consume mask bits.
- R7: A `ret_cancel_i` pulse clears the pending mask and any setup in progress. It wins over a simultaneous `load_i`. From the next cycle, `ready_o`=1, `exec_o`=1 and `pc_inc_o`=1.
- R8: A load replaces the pending pattern completely. An advance in the same cycle as a load consumes nothing.
- R9: A step happens only when `valid_i`, `advance_i` and `ready_o` are all high. Otherwise the pending mask is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Skip instruction taken; load `mask_i` |
| mask_i | input | 32 | Suppression mask, bit 0 = first following instruction |
| ret_cancel_i | input | 1 | Return combined with an empty skip; clears the pattern |
| local_mode_i | input | 1 | 1 = local register memory, 0 = streamed memory |
| valid_i | input | 1 | An instruction slot is present |
| advance_i | input | 1 | The pipeline consumes the current slot |
| ready_o | output | 1 | Low during the setup delay after a load |
| exec_o | output | 1 | 1 = current instruction executes, 0 = cancelled |
| pc_inc_o | output | 4 | Program-counter increment in words for this step |

## Verification
On every cycle, the assertions check the following:
- the streamed-mode increment and polarity;
- the bounds of the local-mode increment and the forced 8-word jump on an all-suppressed step;
- the right shift of the mask by the reported increment;
- the idle behaviour once the mask is empty;
- the drop of `ready_o` after a load;
- clearing on cancel;
- that the mask holds when no step is taken.

Only the bench scenarios can show the following:
- that the exact run lengths of concrete masks give the expected sequence of increments across several steps, including a run longer than eight;
- that the setup delay lasts exactly four cycles;
- that a load replaces a half-consumed pattern.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;
  localparam int unsigned SKIP_MASK_W   = 32;
  localparam int unsigned SKIP_MAX_JUMP = 8;
  localparam int unsigned SKIP_SETUP    = 4;

  typedef enum logic {
    FETCH_STREAM = 1'b0,
    FETCH_LOCAL  = 1'b1
  } fetch_mode_e;
endpackage

// File: rtl/skip_step_calc.sv
module skip_step_calc
  import skip_seq_pkg::*;
#(
  parameter int unsigned MASK_W   = SKIP_MASK_W,
  parameter int unsigned MAX_JUMP = SKIP_MAX_JUMP,
  parameter int unsigned INC_W    = $clog2(MAX_JUMP + 1)
) (
  input  logic [MASK_W-1:0] mask,
  input  fetch_mode_e       mode,
  output logic              exec,
  output logic [INC_W-1:0]  inc
);
  localparam int unsigned SCAN = (MAX_JUMP < MASK_W) ? MAX_JUMP : MASK_W;

  // Count the set bits at the low end of the mask, stopping at the first
  // clear bit or after SCAN positions.
  function automatic logic [INC_W-1:0] low_run(input logic [MASK_W-1:0] m);
    logic [INC_W-1:0] n;
    logic             stop;
    n    = '0;
    stop = 1'b0;
    for (int i = 0; i < SCAN; i++) begin
      if (!stop) begin
        if (m[i]) n = n + INC_W'(1);
        else      stop = 1'b1;
      end
    end
    return n;
  endfunction

  logic [INC_W-1:0] run;
  logic             run_full;

  assign run      = low_run(mask);
  assign run_full = (run == INC_W'(MAX_JUMP));

  always_comb begin
    if (mode == FETCH_LOCAL) begin
      exec = !run_full;
      inc  = run_full ? INC_W'(MAX_JUMP) : run + INC_W'(1);
    end else begin
      exec = !mask[0];
      inc  = INC_W'(1);
    end
  end
endmodule

// File: rtl/skip_setup_timer.sv
module skip_setup_timer
  import skip_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = SKIP_SETUP,
  parameter int unsigned CNT_W     = $clog2(SETUP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic ready
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                left_q <= '0;
    else if (abort)            left_q <= '0;
    else if (start)            left_q <= CNT_W'(SETUP_CYC);
    else if (left_q != '0)     left_q <= left_q - CNT_W'(1);
  end

  assign ready = (left_q == '0);
endmodule

// File: rtl/skip_seq.sv
module skip_seq
  import skip_seq_pkg::*;
#(
  parameter int unsigned MASK_W    = SKIP_MASK_W,
  parameter int unsigned MAX_JUMP  = SKIP_MAX_JUMP,
  parameter int unsigned SETUP_CYC = SKIP_SETUP,
  parameter int unsigned INC_W     = $clog2(MAX_JUMP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              ret_cancel_i,
  input  logic              local_mode_i,
  input  logic              valid_i,
  input  logic              advance_i,
  output logic              ready_o,
  output logic              exec_o,
  output logic [INC_W-1:0]  pc_inc_o
);
  logic [MASK_W-1:0] mask_q;
  logic              step_fire;
  logic              load_take;
  fetch_mode_e       mode;

  assign mode      = local_mode_i ? FETCH_LOCAL : FETCH_STREAM;
  assign load_take = load_i && !ret_cancel_i;
  assign step_fire = valid_i && advance_i && ready_o && !load_i && !ret_cancel_i;

  skip_step_calc #(
    .MASK_W(MASK_W), .MAX_JUMP(MAX_JUMP), .INC_W(INC_W)
  ) u_calc (
    .mask (mask_q),
    .mode (mode),
    .exec (exec_o),
    .inc  (pc_inc_o)
  );

  skip_setup_timer #(
    .SETUP_CYC(SETUP_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (load_take),
    .abort (ret_cancel_i),
    .ready (ready_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            mask_q <= '0;
    else if (ret_cancel_i) mask_q <= '0;
    else if (load_i)       mask_q <= mask_i;
    else if (step_fire)    mask_q <= mask_q >> pc_inc_o;
  end
endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
  parameter int unsigned MASK_W   = 32,
  parameter int unsigned MAX_JUMP = 8,
  parameter int unsigned INC_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              ret_cancel_i,
  input logic              local_mode_i,
  input logic              ready_o,
  input logic              exec_o,
  input logic [INC_W-1:0]  pc_inc_o,
  input logic              step_fire,
  input logic [MASK_W-1:0] mask_q
);
  a_r2_stream_step: assert property (@(posedge clk) disable iff (!rst_n)
    !local_mode_i |-> (pc_inc_o == INC_W'(1)) && (exec_o == !mask_q[0]));

  a_r3_local_inc_range: assert property (@(posedge clk) disable iff (!rst_n)
    (local_mode_i && exec_o) |-> (pc_inc_o >= INC_W'(1)) && (pc_inc_o <= INC_W'(MAX_JUMP)));

  a_r4_full_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (local_mode_i && !exec_o) |-> (pc_inc_o == INC_W'(MAX_JUMP)));

  a_r5_consume: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (mask_q == ($past(mask_q) >> $past(pc_inc_o))));

  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> exec_o && (pc_inc_o == INC_W'(1)));

  a_r6_setup_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !ret_cancel_i) |=> !ready_o);

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    ret_cancel_i |=> (mask_q == '0) && ready_o);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fire && !load_i && !ret_cancel_i) |=> $stable(mask_q));
endmodule

bind skip_seq skip_seq_chk #(
  .MASK_W(MASK_W), .MAX_JUMP(MAX_JUMP), .INC_W(INC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .ret_cancel_i (ret_cancel_i),
  .local_mode_i (local_mode_i),
  .ready_o      (ready_o),
  .exec_o       (exec_o),
  .pc_inc_o     (pc_inc_o),
  .step_fire    (step_fire),
  .mask_q       (mask_q)
);

// File: tb/skip_seq_tb.sv
module skip_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] mask_i = '0;
  logic        ret_cancel_i = 1'b0;
  logic        local_mode_i = 1'b0;
  logic        valid_i = 1'b0;
  logic        advance_i = 1'b0;
  logic        ready_o;
  logic        exec_o;
  logic [3:0]  pc_inc_o;

  typedef struct {
    logic  ex;
    int    inc;
    string req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mm = '0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_seq u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .mask_i(mask_i),
    .ret_cancel_i(ret_cancel_i), .local_mode_i(local_mode_i),
    .valid_i(valid_i), .advance_i(advance_i), .ready_o(ready_o),
    .exec_o(exec_o), .pc_inc_o(pc_inc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of one step, written from R2..R5.
  task automatic push_expect(input string req);
    exp_t e;
    int   run = 0;
    bit   stop = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!stop) begin
        if (mm[i]) run++;
        else stop = 1'b1;
      end
    end
    if (!local_mode_i) begin
      e.ex = !mm[0]; e.inc = 1;
    end else if (run == 8) begin
      e.ex = 1'b0; e.inc = 8;
    end else begin
      e.ex = 1'b1; e.inc = run + 1;
    end
    e.req = req;
    sb.push_back(e);
    mm = mm >> e.inc;
  endtask

  task automatic step(input string req);
    @(negedge clk);
    valid_i = 1'b1; advance_i = 1'b1;
    push_expect(req);
    @(posedge clk); #1;
    valid_i = 1'b0; advance_i = 1'b0;
  endtask

  // Load with full setup observation; poke drives advance during setup,
  // with_adv drives advance in the load cycle itself.
  task automatic load(input logic [31:0] v, input bit poke, input bit with_adv);
    @(negedge clk);
    load_i = 1'b1; mask_i = v; mm = v;
    if (with_adv) begin valid_i = 1'b1; advance_i = 1'b1; end
    @(negedge clk);
    load_i = 1'b0; valid_i = 1'b0; advance_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (poke) begin valid_i = 1'b1; advance_i = 1'b1; end
      #1;
      chk(ready_o == 1'b0, "R6 setup low", ready_o, 0);
      @(negedge clk);
    end
    valid_i = 1'b0; advance_i = 1'b0;
    #1;
    chk(ready_o == 1'b1, "R6 ready after 4", ready_o, 1);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && valid_i && advance_i && ready_o && !load_i && !ret_cancel_i) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected step", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(exec_o == e.ex, {e.req, " exec"}, exec_o, e.ex);
          chk(int'(pc_inc_o) == e.inc, {e.req, " inc"}, pc_inc_o, e.inc);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
    chk(exec_o == 1'b1, "R1 exec", exec_o, 1);
    chk(pc_inc_o == 4'd1, "R1 inc", pc_inc_o, 1);

    // R2: streamed mode, alternating polarity pattern 0x5A
    local_mode_i = 1'b0;
    load(32'h0000_005A, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step("R2 stream");

    // R3/R5: local, 0b0110_0111 -> inc 4,1,3,1
    local_mode_i = 1'b1;
    load(32'h0000_0067, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step("R3 local run");

    // R4: twelve ones then clear -> full jump of 8 then inc 5
    load(32'h0000_0FFF, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step("R4 long run");

    // R4/R5: all ones -> four full jumps then idle
    load(32'hFFFF_FFFF, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step("R5 all ones");

    // R6: advance during setup consumes nothing
    load(32'h0000_0067, 1'b1, 1'b0);
    step("R6 first after setup");

    // R9: valid or advance alone leaves the pattern
    load(32'h0000_0067, 1'b0, 1'b0);
    @(negedge clk); valid_i = 1'b1;
    repeat (3) @(negedge clk);
    valid_i = 1'b0; advance_i = 1'b1;
    repeat (3) @(negedge clk);
    advance_i = 1'b0;
    step("R9 hold");

    // R8: reload mid-pattern with advance in the load cycle
    load(32'h0000_00F7, 1'b0, 1'b0);
    step("R8 before reload");
    load(32'h0000_0003, 1'b0, 1'b1);
    step("R8 replaced");
    step("R8 replaced");

    // R7: cancel during setup, also over a simultaneous load
    @(negedge clk); load_i = 1'b1; mask_i = 32'h0000_00FF;
    @(negedge clk); load_i = 1'b0;
    @(negedge clk); ret_cancel_i = 1'b1; load_i = 1'b1; mask_i = 32'h0000_000F;
    @(negedge clk); ret_cancel_i = 1'b0; load_i = 1'b0; mm = '0;
    #1;
    chk(ready_o == 1'b1, "R7 ready", ready_o, 1);
    chk(exec_o == 1'b1, "R7 exec", exec_o, 1);
    chk(pc_inc_o == 4'd1, "R7 inc", pc_inc_o, 1);
    step("R7 after cancel");
    local_mode_i = 1'b0;
    step("R7 stream after cancel");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule